// File: doc/BRIEF.md
# EDO Data-Output Drive Controller

This block is a cycle-based model of the logic that decides when an extended-data-out DRAM drives its data pins. On every clock it takes the sampled levels of the row strobe, column strobe, write strobe and output enable (all active low). It also takes the read data that the array presents. It produces a data-out bus and a flag saying whether that bus is driven or floating. Access delay is an integer number of clocks, so a testbench can use the block as a checkable reference for the pin-level data behaviour of such a memory.

The defining property is that a rising column strobe does not float the bus: the last word stays on the pins while the next column address is decoded. The bus can be switched off in three ways during column-strobe-high time: output enable held high across the rising edge, a high pulse on output enable, or a low write strobe. Once switched off this way, the bus stays off until the column strobe falls again. A low write strobe at the column fall (early write) keeps the bus floating for the whole cycle. Both strobes high ends the access and drops the held word.

Top module: `edo_dq_drive`

## Requirements
- R1: While `rst` is high at a clock edge, `dq_oe` and `dq_out` are zero after that edge.
- R2: When a falling `cas_n` is first sampled low at edge k with `ras_n` low and `we_n` high, the value of `rd_data` at edge k+CAS_LAT is captured once. After that edge it is on `dq_out` with `dq_oe` high, provided `oe_n` is low.
- R3: A rising `cas_n` with `ras_n` low, `we_n` high and `oe_n` low leaves the bus driven with the same word.
- R4: While both strobes are low and `we_n` is high, `oe_n` high floats the bus after the next edge, and `oe_n` low drives it again.
- R5: If `oe_n` was high at the edge before `cas_n` rises and stays high for OE_HOLD column-high cycles (counting the rise cycle), the bus stays floating until the next `cas_n` fall, even after `oe_n` returns low. A shorter hold lets driving resume.
- R6: If `oe_n` is low when `cas_n` rises, a high pulse of at least OE_PULSE column-high cycles latches the bus off until the next `cas_n` fall. A shorter pulse lets driving resume.
- R7: `we_n` low while `cas_n` is high floats the bus and latches it off until the next `cas_n` fall.
- R8: `we_n` low at the sampled `cas_n` fall floats the bus for that whole column cycle, even if `we_n` later rises, and captures no read data.
- R9: `ras_n` and `cas_n` both high floats the bus and discards the held word. A row-only refresh (`ras_n` low, `cas_n` high) never drives.
- R10: With `cas_n` held low after a read, toggling `ras_n` (hidden refresh) keeps the word driven.
- R11: A new `cas_n` fall within the same row keeps the previous word on the bus until the new word is captured.
- R12: `dq_oe` is high only if `we_n` was high and `oe_n` was low at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| rd_data | input | DW | Word read from the array |
| dq_out | output | DW | Registered data-out value |
| dq_oe | output | 1 | High when the data bus is driven |

## Verification
The bench sweeps the length of the output-enable high interval from one to four cycles in both disable mechanisms. It predicts the latch-off from OE_HOLD or OE_PULSE, so a wrong threshold, a swapped threshold, or a flag that is not sticky all give a visible difference. Page reads are checked at each cycle of the access delay, which separates a held previous word from an early or late capture. Early write, write-strobe cut, hidden refresh and row-only refresh are each driven as their own strobe patterns. The same data values recur across them, so a spurious capture or a word that should have been dropped shows up on the bus.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;
  // Column-strobe events derived from consecutive samples
  typedef struct packed {
    logic cas_fall;
    logic cas_rise;
    logic oe_was_high;
  } strobe_ev_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
  import edo_dq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cas_n,
  input  logic       oe_n,
  output strobe_ev_t ev
);
  logic cas_prev, oe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_prev <= 1'b1;
      oe_prev  <= 1'b1;
    end else begin
      cas_prev <= cas_n;
      oe_prev  <= oe_n;
    end
  end

  assign ev.cas_fall    = cas_prev & ~cas_n;
  assign ev.cas_rise    = ~cas_prev & cas_n;
  assign ev.oe_was_high = oe_prev;
endmodule

// File: rtl/edo_oe_guard.sv
module edo_oe_guard
  import edo_dq_pkg::*;
#(
  parameter int OE_HOLD  = 2,
  parameter int OE_PULSE = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cas_n,
  input  logic       oe_n,
  input  strobe_ev_t ev,
  output logic       trip
);
  localparam int MAXC = max2(OE_HOLD, OE_PULSE);
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] run_q, run_inc, thr;
  logic          pre_q, pre_now;

  // Saturating count of column-high cycles with OE high, this one included
  assign run_inc = (run_q == CW'(MAXC)) ? run_q : run_q + 1'b1;
  // OE already high before the column strobe rose selects the hold threshold
  assign pre_now = ev.cas_rise ? ev.oe_was_high : pre_q;
  assign thr     = pre_now ? CW'(OE_HOLD) : CW'(OE_PULSE);
  assign trip    = cas_n & oe_n & (run_inc >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      pre_q <= 1'b0;
    end else begin
      run_q <= (cas_n & oe_n) ? run_inc : '0;
      pre_q <= oe_n & pre_now;
    end
  end
endmodule

// File: rtl/edo_access_timer.sv
module edo_access_timer #(
  parameter int CAS_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic load
);
  localparam int TW = $clog2(CAS_LAT + 1);

  logic [TW-1:0] cnt_q;

  assign load = (cnt_q == TW'(1)) & ~start & ~abort;

  always_ff @(posedge clk) begin
    if (rst || abort)     cnt_q <= '0;
    else if (start)       cnt_q <= TW'(CAS_LAT);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/edo_dq_drive.sv
module edo_dq_drive
  import edo_dq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CAS_LAT  = 2,
  parameter int OE_HOLD  = 2,
  parameter int OE_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  strobe_ev_t    ev;
  logic          trip, load, start, both_hi;
  logic          off_q, off_d, have_q, have_d, drive_d;
  logic [DW-1:0] data_q, data_d;

  edo_strobe_sampler u_smp (
    .clk(clk), .rst(rst), .cas_n(cas_n), .oe_n(oe_n), .ev(ev)
  );

  edo_oe_guard #(.OE_HOLD(OE_HOLD), .OE_PULSE(OE_PULSE)) u_guard (
    .clk(clk), .rst(rst), .cas_n(cas_n), .oe_n(oe_n), .ev(ev), .trip(trip)
  );

  assign both_hi = ras_n & cas_n;
  assign start   = ev.cas_fall & ~ras_n & we_n;

  edo_access_timer #(.CAS_LAT(CAS_LAT)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .abort(both_hi), .load(load)
  );

  always_comb begin
    // Sticky disable: only a column fall can clear it
    off_d = off_q;
    if (ev.cas_fall)                    off_d = ~we_n;
    else if (both_hi)                   off_d = 1'b1;
    else if (cas_n & (~we_n | trip))    off_d = 1'b1;

    have_d = have_q;
    data_d = data_q;
    if (load) begin
      have_d = 1'b1;
      data_d = rd_data;
    end else if (both_hi) begin
      have_d = 1'b0;
    end

    drive_d = have_d & ~off_d & ~oe_n & we_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= 1'b1;
      have_q <= 1'b0;
      data_q <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      off_q  <= off_d;
      have_q <= have_d;
      data_q <= data_d;
      dq_out <= data_d;
      dq_oe  <= drive_d;
    end
  end
endmodule

// File: rtl/edo_dq_drive_chk.sv
module edo_dq_drive_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dq_oe && dq_out == '0));

  assert_edo_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cas_n) && !ras_n && we_n && !oe_n && dq_oe) |=> dq_oe);

  assert_w_cut_R7: assert property (@(posedge clk) disable iff (rst)
    (cas_n && !we_n) |=> !dq_oe);

  assert_early_write_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |=> !dq_oe);

  assert_refresh_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n) |=> !dq_oe);

  assert_gate_R12: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> ($past(we_n) && !$past(oe_n)));
endmodule

bind edo_dq_drive edo_dq_drive_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_edo_dq_drive.sv
module tb_edo_dq_drive;
  localparam int DW    = 8;
  localparam int LAT   = 2;
  localparam int HOLD  = 2;
  localparam int PULSE = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  int            total = 0;
  int            bad = 0;

  edo_dq_drive #(.DW(DW), .CAS_LAT(LAT), .OE_HOLD(HOLD), .OE_PULSE(PULSE)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_oe(input logic exp, input string tag);
    total++;
    if (dq_oe !== exp) begin
      bad++;
      $display("FAIL %s: dq_oe=%0b expected %0b", tag, dq_oe, exp);
    end
  endtask

  task automatic expect_dq(input logic [DW-1:0] exp, input string tag);
    total++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      bad++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected driven %h", tag, dq_oe, dq_out, exp);
    end
  endtask

  // Column fall within an open row; prior state checked through the access delay
  task automatic read_access(input logic [DW-1:0] d, input logic prev_ok,
                             input logic [DW-1:0] prev, input string tag);
    cas_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; rd_data = d;
    cyc();
    for (int i = 0; i < LAT; i++) begin
      if (prev_ok) expect_dq(prev, tag);
      else         expect_oe(1'b0, tag);
      if (i < LAT - 1) cyc();
    end
    cyc();
    expect_dq(d, tag);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): run not finished, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) cyc();
    expect_oe(1'b0, "R1");
    total++;
    if (dq_out !== '0) begin
      bad++;
      $display("FAIL R1: dq_out=%h expected 00", dq_out);
    end
    rst = 1'b0;
    cyc();
    expect_oe(1'b0, "R1 after release");

    // R2: first read after both strobes high
    ras_n = 1'b0;
    cyc();
    read_access(8'hA5, 1'b0, 8'h00, "R2");
    rd_data = 8'h3C;
    cyc();
    expect_dq(8'hA5, "R2 single capture");

    // R3: extended data out across column rise
    cas_n = 1'b1;
    cyc();
    expect_dq(8'hA5, "R3");
    cyc();
    expect_dq(8'hA5, "R3 held");

    // R7: write strobe during column-high time
    we_n = 1'b0;
    cyc();
    expect_oe(1'b0, "R7");
    we_n = 1'b1;
    cyc();
    expect_oe(1'b0, "R7 latched");
    cyc();
    expect_oe(1'b0, "R7 latched");

    // R11: page read keeps prior word until the new one arrives
    read_access(8'h11, 1'b1, 8'hA5, "R11");

    // R4 / R12: direct OE control while both strobes low
    oe_n = 1'b1;
    cyc();
    expect_oe(1'b0, "R4 R12");
    oe_n = 1'b0;
    cyc();
    expect_dq(8'h11, "R4");

    // R5: OE held high across the column rise, hold length sweep
    for (int len = 1; len <= 4; len++) begin
      oe_n = 1'b1;
      cyc();
      cas_n = 1'b1;
      repeat (len) cyc();
      oe_n = 1'b0;
      cyc();
      expect_oe(len < HOLD, $sformatf("R5 len=%0d", len));
      cas_n = 1'b0;
      cyc();
      expect_dq(8'h11, "R5 re-armed");
    end

    // R6: OE pulse during column-high time, pulse length sweep
    for (int len = 1; len <= 4; len++) begin
      cas_n = 1'b1;
      cyc();
      expect_dq(8'h11, "R6 R3");
      oe_n = 1'b1;
      repeat (len) cyc();
      oe_n = 1'b0;
      cyc();
      expect_oe(len < PULSE, $sformatf("R6 len=%0d", len));
      cas_n = 1'b0;
      cyc();
      expect_dq(8'h11, "R6 re-armed");
    end

    // R8: early write
    cas_n = 1'b1;
    cyc();
    we_n = 1'b0;
    cyc();
    cas_n = 1'b0;
    rd_data = 8'h77;
    cyc();
    expect_oe(1'b0, "R8");
    repeat (LAT + 1) cyc();
    expect_oe(1'b0, "R8 after delay");
    we_n = 1'b1;
    cyc();
    expect_oe(1'b0, "R8 whole cycle");
    cas_n = 1'b1;
    cyc();
    read_access(8'h22, 1'b1, 8'h11, "R8 no capture");

    // R10: hidden refresh with column strobe held low
    ras_n = 1'b1;
    cyc();
    expect_dq(8'h22, "R10");
    ras_n = 1'b0;
    cyc();
    expect_dq(8'h22, "R10");
    ras_n = 1'b1;
    cyc();
    expect_dq(8'h22, "R10");

    // R9: both strobes high, then row-only refresh
    cas_n = 1'b1;
    cyc();
    expect_oe(1'b0, "R9");
    ras_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      expect_oe(1'b0, "R9 row-only");
    end
    ras_n = 1'b1;
    cyc();
    ras_n = 1'b0;
    cyc();
    read_access(8'hC3, 1'b0, 8'h00, "R9 word dropped");

    summary();
    $finish;
  end
endmodule